// File: doc/BRIEF.md
# Serial Configuration Loader for Three Peripheral Chips

This block writes a fixed set of configuration words into three external chips that share one three-wire serial link. The link has a load strobe, a data line and a serial clock. There is also a one-hot chip select with one line per chip. Chip 0 is a timing generator. Chips 1 and 2 are two identical analog front ends. Every register image is a parameter of the block, so the images are fixed when the block is built.

A one-cycle `start` pulse runs the whole load. The block first writes the timing-generator words in index order. It then takes front end A through its register walk and, after that, front end B through the same walk. The walk starts with a power-on word and continues with eight register pairs: operating mode, gain, clamp, control, and the four pixel-gain slots from slot 3 down to slot 0. The walk ends in a finish step that writes no word. After front end B finishes, `done` goes high and stays high.

Each word is shifted MSB first. The serial clock is produced by a clock-enable divider, and its half period depends on which chip is selected. This lets the slower front ends and the faster timing generator share the same pins.

Top module: `serial_cfg_sequencer`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `ser_load`, `ser_clk`, `ser_data`, `busy`, `done` and `chip_sel` are all 0.
- R2: A `start` pulse while idle begins a load, and `busy` is high at the next cycle. A `start` pulse while `busy` is high has no effect: the same number of words, in the same order, is sent.
- R3: The words are sent in this order. First the TG_WORDS timing-generator images, in index order. Then 17 front-end words to front end A: power-on word (image index 0), then index 1 to 16 (mode 1/2, gain 1/2, clamp 1/2, control 1/2, pixel-gain slot 3 to slot 0, first then second word of each). Then the same 17 images to front end B.
- R4: Each word is exactly WORD_W bits long, MSB first, one bit per rising edge of `ser_clk`.
- R5: `ser_data` changes only when `ser_clk` falls or while it is low. It never changes while `ser_clk` stays high.
- R6: `ser_load` stays high from the first data bit to the last falling edge of the word. It then stays low for at least two serial half periods before the next word starts.
- R7: `chip_sel` has at most one bit set: bit 0 is the timing generator, bit 1 front end A, bit 2 front end B. It is nonzero and unchanged for at least one cycle before `ser_load` rises, and it stays unchanged while `ser_load` is high.
- R8: Every high phase and low phase of `ser_clk` inside a word lasts HALF_TG clock cycles for the timing generator and HALF_FE cycles for either front end. The time from the rise of `ser_load` to the first rising edge is also one half period.
- R9: `done` rises after the last word of front end B and stays high until the next `start`. `done` and `busy` are never high together, and `ser_load` is high only while `busy` is high.
- R10: A `start` pulse after `done` clears `done` at the next cycle and sends the complete sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a full configuration load |
| ser_load | output | 1 | Load strobe, high for the whole transfer of one word |
| ser_data | output | 1 | Serial data, MSB first |
| ser_clk | output | 1 | Serial clock, idles low |
| chip_sel | output | 3 | One-hot target select (bit 0 timing generator, bits 1 and 2 front ends) |
| busy | output | 1 | High while a load is in progress |
| done | output | 1 | High once the full load has completed |

## Verification
The bench builds the block with 16-bit words and two timing-generator words. It sets HALF_TG to 2 and HALF_FE to 3, so the two serial clock rates differ and a wrong rate choice shows up as a wrong half-period length. Each image word gets its own value, computed by the bench, so a skipped, repeated or reordered step, a swapped chip select or a bit-order error changes the words recorded at the pins. These settings keep the full 36-word sequence short enough to run it twice, to inject a start in the middle of a load, and to apply a reset during a transfer.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int FE_WORDS = 17;
    localparam int NUM_CHIPS = 3;

    typedef enum logic [1:0] {
        TGT_TIMING = 2'd0,
        TGT_FE_A   = 2'd1,
        TGT_FE_B   = 2'd2
    } target_e;

    // Order of this enum is the order of the front-end register walk.
    typedef enum logic [4:0] {
        ST_TIMING,
        ST_PWR_ON,
        ST_MODE_1, ST_MODE_2,
        ST_GAIN_1, ST_GAIN_2,
        ST_CLAMP_1, ST_CLAMP_2,
        ST_CTL_1, ST_CTL_2,
        ST_PIX3_1, ST_PIX3_2,
        ST_PIX2_1, ST_PIX2_2,
        ST_PIX1_1, ST_PIX1_2,
        ST_PIX0_1, ST_PIX0_2,
        ST_FE_FINISH
    } step_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_GAP
    } shift_ph_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_ISSUE,
        CT_WAIT
    } ctl_ph_e;

    function automatic int fe_index(step_e s);
        return int'(s) - int'(ST_PWR_ON);
    endfunction

    function automatic logic [NUM_CHIPS-1:0] sel_decode(target_e t, logic act);
        logic [NUM_CHIPS-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_CHIPS; i++) begin
            if (act && int'(t) == i) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/serial_cfg_tick.sv
module serial_cfg_tick #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == half - CNT_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/serial_cfg_shifter.sv
module serial_cfg_shifter
    import serial_cfg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [WORD_W-1:0] word,
    input  logic              tick,
    output logic              ser_load,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              active,
    output logic              fin
);
    localparam int BIT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    shift_ph_e         ph;
    logic [WORD_W-1:0] sreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic              gap_seen;

    assign active = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            sreg     <= '0;
            bit_cnt  <= '0;
            gap_seen <= 1'b0;
            ser_load <= 1'b0;
            ser_data <= 1'b0;
            ser_clk  <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (load_req) begin
                        sreg <= word;
                        ph   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (tick) begin
                        ser_load <= 1'b1;
                        ser_data <= sreg[WORD_W-1];
                        bit_cnt  <= BIT_W'(WORD_W - 1);
                        ph       <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        ser_clk <= 1'b1;
                        ph      <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        ser_clk <= 1'b0;
                        if (bit_cnt == '0) begin
                            ser_load <= 1'b0;
                            ser_data <= 1'b0;
                            gap_seen <= 1'b0;
                            ph       <= PH_GAP;
                        end else begin
                            sreg     <= sreg << 1;
                            ser_data <= sreg[WORD_W-2];
                            bit_cnt  <= bit_cnt - BIT_W'(1);
                            ph       <= PH_LOW;
                        end
                    end
                end
                PH_GAP: begin
                    if (tick) begin
                        if (gap_seen) begin
                            ph  <= PH_IDLE;
                            fin <= 1'b1;
                        end else begin
                            gap_seen <= 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
    import serial_cfg_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int TG_WORDS = 4,
    parameter int CNT_W    = 8,
    parameter int HALF_TG  = 2,
    parameter int HALF_FE  = 4,
    parameter logic [TG_WORDS*WORD_W-1:0] TG_IMG = '0,
    parameter logic [FE_WORDS*WORD_W-1:0] FE_IMG = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 fin,
    output logic                 req,
    output logic [WORD_W-1:0]    word,
    output logic [CNT_W-1:0]     half,
    output logic [NUM_CHIPS-1:0] chip_sel,
    output logic                 busy,
    output logic                 done
);
    localparam int TGI_W = (TG_WORDS > 1) ? $clog2(TG_WORDS) : 1;

    ctl_ph_e          ph;
    step_e            step;
    target_e          target;
    logic [TGI_W-1:0] tg_idx;

    assign busy     = (ph != CT_IDLE);
    assign chip_sel = sel_decode(target, busy);
    assign half     = (target == TGT_TIMING) ? CNT_W'(HALF_TG) : CNT_W'(HALF_FE);

    always_comb begin
        int fi;
        fi   = fe_index(step);
        word = '0;
        if (step == ST_TIMING) begin
            word = TG_IMG[int'(tg_idx)*WORD_W +: WORD_W];
        end else if (fi >= 0 && fi < FE_WORDS) begin
            word = FE_IMG[fi*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= CT_IDLE;
            step   <= ST_TIMING;
            target <= TGT_TIMING;
            tg_idx <= '0;
            req    <= 1'b0;
            done   <= 1'b0;
        end else begin
            req <= 1'b0;
            case (ph)
                CT_IDLE: begin
                    if (start) begin
                        done   <= 1'b0;
                        target <= TGT_TIMING;
                        step   <= ST_TIMING;
                        tg_idx <= '0;
                        ph     <= CT_ISSUE;
                    end
                end
                CT_ISSUE: begin
                    if (step == ST_FE_FINISH) begin
                        if (target == TGT_FE_A) begin
                            target <= TGT_FE_B;
                            step   <= ST_PWR_ON;
                        end else begin
                            done <= 1'b1;
                            ph   <= CT_IDLE;
                        end
                    end else begin
                        req <= 1'b1;
                        ph  <= CT_WAIT;
                    end
                end
                CT_WAIT: begin
                    if (fin) begin
                        ph <= CT_ISSUE;
                        if (step == ST_TIMING) begin
                            if (int'(tg_idx) == TG_WORDS - 1) begin
                                target <= TGT_FE_A;
                                step   <= ST_PWR_ON;
                            end else begin
                                tg_idx <= tg_idx + TGI_W'(1);
                            end
                        end else begin
                            step <= step_e'(5'(step) + 5'd1);
                        end
                    end
                end
                default: ph <= CT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_cfg_sequencer.sv
module serial_cfg_sequencer
    import serial_cfg_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int TG_WORDS = 4,
    parameter int CNT_W    = 8,
    parameter int HALF_TG  = 2,
    parameter int HALF_FE  = 4,
    parameter logic [TG_WORDS*WORD_W-1:0] TG_IMG = {TG_WORDS{WORD_W'(16'hA5C3)}},
    parameter logic [FE_WORDS*WORD_W-1:0] FE_IMG = {FE_WORDS{WORD_W'(16'h8421)}}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       ser_load,
    output logic       ser_data,
    output logic       ser_clk,
    output logic [2:0] chip_sel,
    output logic       busy,
    output logic       done
);
    logic              req;
    logic              fin;
    logic              tick;
    logic              active;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  half;

    serial_cfg_ctrl #(
        .WORD_W  (WORD_W),
        .TG_WORDS(TG_WORDS),
        .CNT_W   (CNT_W),
        .HALF_TG (HALF_TG),
        .HALF_FE (HALF_FE),
        .TG_IMG  (TG_IMG),
        .FE_IMG  (FE_IMG)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fin     (fin),
        .req     (req),
        .word    (word),
        .half    (half),
        .chip_sel(chip_sel),
        .busy    (busy),
        .done    (done)
    );

    serial_cfg_tick #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .restart(req),
        .run    (active),
        .half   (half),
        .tick   (tick)
    );

    serial_cfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_req(req),
        .word    (word),
        .tick    (tick),
        .ser_load(ser_load),
        .ser_data(ser_data),
        .ser_clk (ser_clk),
        .active  (active),
        .fin     (fin)
    );
endmodule

// File: rtl/serial_cfg_checker.sv
module serial_cfg_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       ser_load,
    input logic       ser_data,
    input logic       ser_clk,
    input logic [2:0] chip_sel,
    input logic       busy,
    input logic       done
);
    a_r7_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chip_sel));

    a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
        (ser_load && $past(ser_load)) |-> $stable(chip_sel));

    a_r7_load_has_sel: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> (chip_sel != 3'b000));

    a_r5_data_still_high: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    a_r6_clk_inside_load: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> ser_load);

    a_r9_not_both: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r9_load_busy: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> busy);
endmodule

bind serial_cfg_sequencer serial_cfg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ser_load(ser_load),
    .ser_data(ser_data),
    .ser_clk (ser_clk),
    .chip_sel(chip_sel),
    .busy    (busy),
    .done    (done)
);

// File: tb/serial_cfg_sequencer_bench.sv
module serial_cfg_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W       = 16;
    localparam int TG_N    = 2;
    localparam int FE_N    = 17;
    localparam int HALF_TG = 2;
    localparam int HALF_FE = 3;
    localparam int EXP_N   = TG_N + 2 * FE_N;

    function automatic logic [W-1:0] tg_word(int i);
        return 16'hA005 + 16'(i) * 16'h0111;
    endfunction

    function automatic logic [W-1:0] fe_word(int k);
        return 16'h8001 ^ (16'(k) << 8) ^ 16'(k * 3);
    endfunction

    function automatic logic [TG_N*W-1:0] tg_flat();
        logic [TG_N*W-1:0] f;
        for (int i = 0; i < TG_N; i++) f[i*W +: W] = tg_word(i);
        return f;
    endfunction

    function automatic logic [FE_N*W-1:0] fe_flat();
        logic [FE_N*W-1:0] f;
        for (int k = 0; k < FE_N; k++) f[k*W +: W] = fe_word(k);
        return f;
    endfunction

    typedef logic [EXP_N-1:0][W+2:0] tab_t;

    function automatic tab_t build_tab();
        tab_t t;
        for (int i = 0; i < TG_N; i++) t[i] = {3'b001, tg_word(i)};
        for (int k = 0; k < FE_N; k++) begin
            t[TG_N + k]        = {3'b010, fe_word(k)};
            t[TG_N + FE_N + k] = {3'b100, fe_word(k)};
        end
        return t;
    endfunction

    localparam tab_t EXP_TAB = build_tab();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ser_load, ser_data, ser_clk, busy, done;
    logic [2:0] chip_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_sequencer #(
        .WORD_W  (W),
        .TG_WORDS(TG_N),
        .CNT_W   (6),
        .HALF_TG (HALF_TG),
        .HALF_FE (HALF_FE),
        .TG_IMG  (tg_flat()),
        .FE_IMG  (fe_flat())
    ) u_serial_cfg_sequencer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ser_load(ser_load),
        .ser_data(ser_data),
        .ser_clk (ser_clk),
        .chip_sel(chip_sel),
        .busy    (busy),
        .done    (done)
    );

    // ---------------- pin monitor ----------------
    logic         p_load, p_clk, p_data;
    logic [2:0]   p_sel, cur_sel;
    logic [W-1:0] cur_word;
    int cur_bits, cnt, gap_low, last_half;
    int err_r5 = 0, err_r6 = 0, err_r7 = 0, err_r8 = 0;
    int rec_n = 0;
    logic [W-1:0] rec_word [0:127];
    logic [2:0]   rec_sel  [0:127];
    int           rec_bits [0:127];

    function automatic int hf(logic [2:0] s);
        return (s == 3'b001) ? HALF_TG : HALF_FE;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            p_load = 0; p_clk = 0; p_data = 0; p_sel = 0; cur_sel = 0;
            cur_word = 0; cur_bits = 0; cnt = 0; gap_low = 100; last_half = 0;
        end else begin
            cnt = cnt + 1;
            if (ser_load && !p_load) begin
                if (chip_sel == 3'b000 || chip_sel != p_sel) err_r7++;
                if (gap_low < 2 * last_half) err_r6++;
                cur_sel = chip_sel; cur_word = 0; cur_bits = 0; cnt = 0;
            end
            if (ser_load && p_load && chip_sel != cur_sel) err_r7++;
            if (ser_clk != p_clk) begin
                if (cnt != hf(cur_sel)) err_r8++;
                cnt = 0;
                if (ser_clk) begin
                    cur_word = {cur_word[W-2:0], ser_data};
                    cur_bits++;
                end
            end
            if (p_clk && ser_clk && ser_data != p_data) err_r5++;
            if (!ser_load && p_load) begin
                if (rec_n < 128) begin
                    rec_word[rec_n] = cur_word;
                    rec_sel[rec_n]  = cur_sel;
                    rec_bits[rec_n] = cur_bits;
                end
                rec_n++;
                last_half = hf(cur_sel);
                gap_low = 0;
            end
            if (!ser_load) gap_low++;
            p_load = ser_load; p_clk = ser_clk; p_data = ser_data; p_sel = chip_sel;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        bit ok;
        int base;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk({ser_load, ser_clk, ser_data, busy, done, chip_sel} == 8'h00, "R1 outputs during reset",
            {ser_load, ser_clk, ser_data, busy, done, chip_sel}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk({ser_load, ser_clk, ser_data, busy, done, chip_sel} == 8'h00, "R1 idle after reset",
            {ser_load, ser_clk, ser_data, busy, done, chip_sel}, 0);

        // R2: start begins a load
        base = rec_n;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        // R2: start while busy is ignored
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(ok);
        chk(ok, "R9 done reached", ok, 1);
        repeat (2) @(negedge clk);
        chk(rec_n - base == EXP_N, "R2 word count with mid-run start", rec_n - base, EXP_N);

        // R3 / R4 / R7: walk the expected table
        for (int i = 0; i < EXP_N; i++) begin
            chk(rec_sel[base + i] == EXP_TAB[i][W+2:W], $sformatf("R7 select of word %0d", i),
                rec_sel[base + i], EXP_TAB[i][W+2:W]);
            chk(rec_word[base + i] == EXP_TAB[i][W-1:0], $sformatf("R3 value of word %0d", i),
                rec_word[base + i], EXP_TAB[i][W-1:0]);
            chk(rec_bits[base + i] == W, $sformatf("R4 bit count of word %0d", i),
                rec_bits[base + i], W);
        end

        chk(err_r5 == 0, "R5 data moved while clock high", err_r5, 0);
        chk(err_r6 == 0, "R6 inter-word gap too short", err_r6, 0);
        chk(err_r7 == 0, "R7 select unstable or missing", err_r7, 0);
        chk(err_r8 == 0, "R8 half-period length", err_r8, 0);

        // R9: done held, busy low
        repeat (50) @(negedge clk);
        chk(done == 1'b1, "R9 done held", done, 1);
        chk(busy == 1'b0 && ser_load == 1'b0 && chip_sel == 3'b000, "R9 idle with done",
            {busy, ser_load, chip_sel}, 0);

        // R10: restart after done
        base = rec_n;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R10 done cleared by start", done, 0);
        chk(busy == 1'b1, "R10 busy on restart", busy, 1);
        wait_done(ok);
        chk(ok, "R10 second load completes", ok, 1);
        repeat (2) @(negedge clk);
        chk(rec_n - base == EXP_N, "R10 second load word count", rec_n - base, EXP_N);
        chk(rec_word[base] == EXP_TAB[0][W-1:0], "R10 first word again", rec_word[base], EXP_TAB[0][W-1:0]);
        chk(rec_word[base + EXP_N - 1] == EXP_TAB[EXP_N-1][W-1:0], "R3 last word again",
            rec_word[base + EXP_N - 1], EXP_TAB[EXP_N-1][W-1:0]);

        // R1: reset in the middle of a transfer
        pulse_start();
        repeat (120) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({ser_load, ser_clk, ser_data, busy, done, chip_sel} == 8'h00, "R1 reset during transfer",
            {ser_load, ser_clk, ser_data, busy, done, chip_sel}, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule